// File: doc/BRIEF.md
# Teletext Service Packet Acquisition Unit

This block sits behind a teletext byte deframer. It takes the bytes of a broadcast service packet (row 8/30), one per strobe, each with its byte index and a flag that gives the packet format. Format 1 packets carry date and time bytes, which are kept exactly as received. Format 2 packets carry label bytes, each protected by a Hamming 8/4 code. Every format 2 byte is checked, and a byte with a single bit error is corrected.

At the end of a packet the staged bytes are committed into a seven-byte image that a host reads. Each format has its own image and its own packing map. A select input chooses which image appears on the output. A committed format 2 packet pulls the active-low data-available line low. A committed format 1 packet leaves that line alone, so the host has to poll for it. The line returns high at the start of the next data-entry window. While the host is accessing the block, nothing is committed.

Top module: `svc_pkt_acq`

## Requirements
- R1: After reset both images read all ones (0xFF in every host byte), and `dav_n_o` is high.
- R2: A format 2 byte holds protection bits at byte bits 0, 2, 4, 6 and message bits m0..m3 at byte bits 1, 3, 5, 7. Bit 0 is the first bit transmitted. The checks use even parity: bit0 = m0^m2^m3, bit2 = m0^m1^m3, bit4 = m0^m1^m2, and bit 6 makes the whole byte even. Any single flipped bit, including bit 6, is corrected.
- R3: A format 2 byte that is at even distance ≥2 from every codeword is a double error. Its staged nibble is left unchanged and the whole packet is discarded at commit: the format 2 image and `dav_n_o` keep their values.
- R4: The format 2 image places received bytes 13..25 as follows. Host bytes 1 to 6 hold the pairs (16,17), (18,19), (20,21), (22,23), (14,15) and (24,25), with the first byte of each pair in the upper nibble. Host byte 7 holds byte 13 in its upper nibble and 1111 in its lower nibble. In every nibble, m0 sits in the highest bit.
- R5: Format 1 bytes 15..21 fill host bytes 1..7 in index order, with no bit changed. Received bit 0 goes to host bit 7, so the bit order within the byte is reversed.
- R6: A format 2 commit without a double error drives `dav_n_o` low on the edge at which `pkt_end_i` is sampled.
- R7: A format 1 commit never changes `dav_n_o`.
- R8: `field_start_i` sets `dav_n_o` high. If a valid format 2 commit falls in the same cycle, the commit wins and `dav_n_o` goes low.
- R9: While `host_busy_i` is high, a packet end commits nothing. The staged packet is dropped, and neither image nor `dav_n_o` is lowered.
- R10: With `host_sel_i` at 0 the format 2 image is on `img_o`; with it at 1 the format 1 image is shown. Host byte 1 is at `img_o[55:48]`.
- R11: Bytes whose index is outside the range of their format are ignored, and a double error in such a byte does not spoil the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld_i | input | 1 | Byte strobe |
| byte_idx_i | input | 5 | Byte index within the packet |
| byte_dat_i | input | 8 | Received byte, bit 0 first transmitted |
| fmt2_i | input | 1 | 1 = format 2, 0 = format 1 (for bytes and packet end) |
| pkt_end_i | input | 1 | Commit the staged packet of format `fmt2_i` |
| field_start_i | input | 1 | Start of a new data-entry window |
| host_busy_i | input | 1 | Host access in progress, commits blocked |
| host_sel_i | input | 1 | Image select: 0 format 2, 1 format 1 |
| img_o | output | 56 | Seven-byte host image, host byte 1 in the top byte |
| dav_n_o | output | 1 | Data available, active low |

## Verification
Two events can fall in one cycle. The first pair is a packet end and a host access; the second is a valid format 2 commit and the start of a data-entry window. The bench raises `host_busy_i` and `field_start_i` at random on the cycle of `pkt_end_i`, and also drives each pairing in directed form. After every packet end it compares both images and `dav_n_o` against a model. That model drops blocked packets and lets the commit win over the window start.

// File: rtl/svc_pkt_pkg.sv
package svc_pkt_pkg;
   localparam int BYTE_W = 8;
   localparam int NIB_W  = 4;

   typedef struct packed {
      logic [NIB_W-1:0] msg;
      logic             dbl;
   } ham_out_t;

   function automatic logic [BYTE_W-1:0] rev8(input logic [BYTE_W-1:0] v);
      logic [BYTE_W-1:0] r;
      for (int i = 0; i < BYTE_W; i++) r[i] = v[BYTE_W-1-i];
      return r;
   endfunction

   function automatic logic [NIB_W-1:0] rev4(input logic [NIB_W-1:0] v);
      logic [NIB_W-1:0] r;
      for (int i = 0; i < NIB_W; i++) r[i] = v[NIB_W-1-i];
      return r;
   endfunction
endpackage

// File: rtl/ham84_dec.sv
module ham84_dec
   import svc_pkt_pkg::*;
(
   input  logic [BYTE_W-1:0] code_i,
   output ham_out_t          res_o
);
   logic sa, sb, sc, sp;
   logic [NIB_W-1:0] flip;

   always_comb begin
      sa = code_i[0] ^ code_i[1] ^ code_i[5] ^ code_i[7];
      sb = code_i[1] ^ code_i[2] ^ code_i[3] ^ code_i[7];
      sc = code_i[1] ^ code_i[3] ^ code_i[4] ^ code_i[5];
      sp = ^code_i;
      // odd overall parity means one error: syndrome points at the bit
      flip = sp ? {sa & sb & ~sc, sa & ~sb & sc, ~sa & sb & sc, sa & sb & sc}
                : '0;
      res_o.msg = {code_i[7], code_i[5], code_i[3], code_i[1]} ^ flip;
      res_o.dbl = ~sp & (sa | sb | sc);
   end
endmodule

// File: rtl/f1_capture.sv
module f1_capture
   import svc_pkt_pkg::*;
#(
   parameter int IDX_W     = 5,
   parameter int FIRST_IDX = 15,
   parameter int N_BYTES   = 7
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_i,
   input  logic [IDX_W-1:0]          idx_i,
   input  logic [BYTE_W-1:0]         dat_i,
   input  logic                      commit_i,
   output logic [N_BYTES*BYTE_W-1:0] img_o
);
   localparam int IMG_W = N_BYTES * BYTE_W;

   if (FIRST_IDX + N_BYTES > (1 << IDX_W)) begin : g_chk_range
      $error("f1_capture: index range exceeds IDX_W");
   end

   logic [IMG_W-1:0] stage_q;
   logic [IMG_W-1:0] img_q;

   for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(FIRST_IDX + g);
      localparam int POS = (N_BYTES - 1 - g) * BYTE_W;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            stage_q[POS +: BYTE_W] <= '1;
         else if (wr_i && idx_i == MY_IDX)
            stage_q[POS +: BYTE_W] <= rev8(dat_i);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        img_q <= '1;
      else if (commit_i) img_q <= stage_q;
   end

   assign img_o = img_q;
endmodule

// File: rtl/f2_capture.sv
module f2_capture
   import svc_pkt_pkg::*;
#(
   parameter int IDX_W      = 5,
   parameter int FIRST_IDX  = 13,
   parameter int HOST_BYTES = 7
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_i,
   input  logic [IDX_W-1:0]             idx_i,
   input  logic [BYTE_W-1:0]            dat_i,
   input  logic                         commit_i,
   input  logic                         clear_i,
   output logic                         bad_o,
   output logic [HOST_BYTES*BYTE_W-1:0] img_o
);
   localparam int N_NIB = 2 * HOST_BYTES - 1;
   localparam int IMG_W = HOST_BYTES * BYTE_W;

   if (HOST_BYTES != 7) begin : g_chk_map
      $error("f2_capture: packing map is defined for seven host bytes");
   end
   if (FIRST_IDX + N_NIB > (1 << IDX_W)) begin : g_chk_range
      $error("f2_capture: index range exceeds IDX_W");
   end

   // offset (from FIRST_IDX) of the upper nibble of host byte h
   function automatic int pair_first(input int h);
      case (h)
         0:       return 3;
         1:       return 5;
         2:       return 7;
         3:       return 9;
         4:       return 1;
         default: return 11;
      endcase
   endfunction

   ham_out_t         dec;
   logic [NIB_W-1:0] nib_q [N_NIB];
   logic             bad_q;
   logic [IMG_W-1:0] packed_img;
   logic [IMG_W-1:0] img_q;
   logic             in_rng;

   ham84_dec u_dec (.code_i(dat_i), .res_o(dec));

   assign in_rng = (idx_i >= IDX_W'(FIRST_IDX)) &&
                   (idx_i <= IDX_W'(FIRST_IDX + N_NIB - 1));

   for (genvar n = 0; n < N_NIB; n++) begin : g_nib
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(FIRST_IDX + n);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            nib_q[n] <= '1;
         else if (wr_i && idx_i == MY_IDX && !dec.dbl)
            nib_q[n] <= dec.msg;
      end
   end

   for (genvar h = 0; h < HOST_BYTES - 1; h++) begin : g_pack
      localparam int UP  = pair_first(h);
      localparam int POS = (HOST_BYTES - 1 - h) * BYTE_W;
      assign packed_img[POS +: BYTE_W] = {rev4(nib_q[UP]), rev4(nib_q[UP+1])};
   end
   assign packed_img[BYTE_W-1:0] = {rev4(nib_q[0]), {NIB_W{1'b1}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  bad_q <= 1'b0;
      else if (clear_i)            bad_q <= 1'b0;
      else if (wr_i && in_rng && dec.dbl) bad_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  img_q <= '1;
      else if (commit_i && !bad_q) img_q <= packed_img;
   end

   assign bad_o = bad_q;
   assign img_o = img_q;

   // R3: a packet flagged with a double error never reaches the image
   a_r3_drop_bad: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_i && bad_q) |=> $stable(img_q));
endmodule

// File: rtl/svc_pkt_acq.sv
module svc_pkt_acq
   import svc_pkt_pkg::*;
#(
   parameter int IDX_W      = 5,
   parameter int HOST_BYTES = 7,
   parameter int F1_FIRST   = 15,
   parameter int F2_FIRST   = 13
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         byte_vld_i,
   input  logic [IDX_W-1:0]             byte_idx_i,
   input  logic [7:0]                   byte_dat_i,
   input  logic                         fmt2_i,
   input  logic                         pkt_end_i,
   input  logic                         field_start_i,
   input  logic                         host_busy_i,
   input  logic                         host_sel_i,
   output logic [HOST_BYTES*8-1:0]      img_o,
   output logic                         dav_n_o
);
   localparam int IMG_W = HOST_BYTES * BYTE_W;

   logic             wr1, wr2, commit1, commit2;
   logic             f2_bad;
   logic [IMG_W-1:0] f1_img, f2_img;
   logic             dav_n_q;

   assign wr1     = byte_vld_i & ~fmt2_i;
   assign wr2     = byte_vld_i &  fmt2_i;
   assign commit1 = pkt_end_i & ~fmt2_i & ~host_busy_i;
   assign commit2 = pkt_end_i &  fmt2_i & ~host_busy_i;

   f1_capture #(.IDX_W(IDX_W), .FIRST_IDX(F1_FIRST), .N_BYTES(HOST_BYTES)) u_f1 (
      .clk(clk), .rst_n(rst_n), .wr_i(wr1), .idx_i(byte_idx_i),
      .dat_i(byte_dat_i), .commit_i(commit1), .img_o(f1_img));

   f2_capture #(.IDX_W(IDX_W), .FIRST_IDX(F2_FIRST), .HOST_BYTES(HOST_BYTES)) u_f2 (
      .clk(clk), .rst_n(rst_n), .wr_i(wr2), .idx_i(byte_idx_i),
      .dat_i(byte_dat_i), .commit_i(commit2), .clear_i(pkt_end_i & fmt2_i),
      .bad_o(f2_bad), .img_o(f2_img));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  dav_n_q <= 1'b1;
      else if (commit2 && !f2_bad) dav_n_q <= 1'b0;
      else if (field_start_i)      dav_n_q <= 1'b1;
   end

   assign img_o   = host_sel_i ? f1_img : f2_img;
   assign dav_n_o = dav_n_q;

   // R6: data-available only falls on an unblocked format 2 packet end
   a_r6_dav_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dav_n_q) |-> $past(pkt_end_i && fmt2_i && !host_busy_i));
   // R8: data-available only rises at a window start
   a_r8_dav_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dav_n_q) |-> $past(field_start_i));
   // R7: a format 1 packet end leaves a high data-available high
   a_r7_f1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_end_i && !fmt2_i && dav_n_q) |=> dav_n_q);
   // R9: nothing is written during a host access
   a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      host_busy_i |=> ($stable(f1_img) && $stable(f2_img) && !$fell(dav_n_q)));
endmodule

// File: tb/svc_pkt_acq_tb.sv
module svc_pkt_acq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        byte_vld = 1'b0;
   logic [4:0]  byte_idx = '0;
   logic [7:0]  byte_dat = '0;
   logic        fmt2 = 1'b0;
   logic        pkt_end = 1'b0;
   logic        field_start = 1'b0;
   logic        host_busy = 1'b0;
   logic        host_sel = 1'b0;
   logic [55:0] img;
   logic        dav_n;

   int total = 0;
   int bad = 0;

   // bench model
   logic [7:0]  s1 [7];
   logic [3:0]  sn [13];
   logic        sbad;
   logic [55:0] e1, e2;
   logic        edav;

   svc_pkt_acq u_dut (
      .clk(clk), .rst_n(rst_n), .byte_vld_i(byte_vld), .byte_idx_i(byte_idx),
      .byte_dat_i(byte_dat), .fmt2_i(fmt2), .pkt_end_i(pkt_end),
      .field_start_i(field_start), .host_busy_i(host_busy),
      .host_sel_i(host_sel), .img_o(img), .dav_n_o(dav_n));

   always #2 clk = ~clk;

   function automatic logic [7:0] b_rev8(input logic [7:0] v);
      logic [7:0] r;
      for (int i = 0; i < 8; i++) r[7-i] = v[i];
      return r;
   endfunction

   function automatic logic [3:0] b_rev4(input logic [3:0] v);
      return {v[0], v[1], v[2], v[3]};
   endfunction

   // R2 encoding: bits 1,3,5,7 = m0..m3, even checks in 0,2,4, bit 6 overall
   function automatic logic [7:0] benc(input logic [3:0] m);
      logic [7:0] c;
      c[1] = m[0]; c[3] = m[1]; c[5] = m[2]; c[7] = m[3];
      c[0] = m[0] ^ m[2] ^ m[3];
      c[2] = m[0] ^ m[1] ^ m[3];
      c[4] = m[0] ^ m[1] ^ m[2];
      c[6] = c[0] ^ c[1] ^ c[2] ^ c[3] ^ c[4] ^ c[5] ^ c[7];
      return c;
   endfunction

   // nearest codeword search: {bad, nibble}
   function automatic logic [4:0] bdec(input logic [7:0] c);
      int best = 99;
      logic [3:0] bn = '0;
      for (int v = 0; v < 16; v++) begin
         int d = $countones(c ^ benc(v[3:0]));
         if (d < best) begin best = d; bn = v[3:0]; end
      end
      return {best > 1, bn};
   endfunction

   function automatic logic [55:0] pack2();
      logic [55:0] r;
      int ups [6] = '{3, 5, 7, 9, 1, 11};
      for (int h = 0; h < 6; h++)
         r[(6-h)*8 +: 8] = {b_rev4(sn[ups[h]]), b_rev4(sn[ups[h]+1])};
      r[7:0] = {b_rev4(sn[0]), 4'hF};
      return r;
   endfunction

   function automatic logic [55:0] pack1();
      logic [55:0] r;
      for (int i = 0; i < 7; i++) r[(6-i)*8 +: 8] = s1[i];
      return r;
   endfunction

   task automatic chk(input string req, input logic [55:0] act, input logic [55:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic send(input int idx, input logic [7:0] dat, input logic f2);
      byte_vld = 1'b1; byte_idx = idx[4:0]; byte_dat = dat; fmt2 = f2;
      @(negedge clk);
      byte_vld = 1'b0;
      if (!f2 && idx >= 15 && idx <= 21) s1[idx-15] = b_rev8(dat);
      if (f2 && idx >= 13 && idx <= 25) begin
         logic [4:0] d = bdec(dat);
         if (d[4]) sbad = 1'b1;
         else      sn[idx-13] = d[3:0];
      end
   endtask

   task automatic finish_pkt(input logic f2, input logic busy, input logic fs, input string req);
      pkt_end = 1'b1; fmt2 = f2; host_busy = busy; field_start = fs;
      @(negedge clk);
      pkt_end = 1'b0; host_busy = 1'b0; field_start = 1'b0;
      if (fs) edav = 1'b1;
      if (f2 && !busy && !sbad) begin e2 = pack2(); edav = 1'b0; end
      if (!f2 && !busy) e1 = pack1();
      if (f2) sbad = 1'b0;
      host_sel = 1'b0; #1;
      chk({req, " R4 R10 fmt2 image"}, img, e2);
      host_sel = 1'b1; #1;
      chk({req, " R5 R10 fmt1 image"}, img, e1);
      chk({req, " R6 R7 R8 dav"}, {55'd0, dav_n}, {55'd0, edav});
   endtask

   function automatic logic [7:0] corrupt(input logic [7:0] c, input int n);
      logic [7:0] r = c;
      int a = $urandom_range(7);
      int b = (a + 1 + $urandom_range(6)) % 8;
      if (n >= 1) r[a] = ~r[a];
      if (n >= 2) r[b] = ~r[b];
      return r;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      $display("FAIL watchdog R1 act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0830));
      for (int i = 0; i < 7; i++) s1[i] = 8'hFF;
      for (int i = 0; i < 13; i++) sn[i] = 4'hF;
      sbad = 1'b0; e1 = '1; e2 = '1; edav = 1'b1;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 fmt2 image", img, '1);
      chk("R1 dav", {55'd0, dav_n}, {55'd0, 1'b1});
      rst_n = 1'b1;
      @(negedge clk);
      host_sel = 1'b1; #1;
      chk("R1 fmt1 image", img, '1);

      // directed R2: every single-bit error position, incl. bit 6
      for (int k = 0; k < 13; k++) begin
         logic [7:0] c = benc(4'((k * 5 + 3) % 16));
         if (k < 8) c[k] = ~c[k];
         send(13 + k, c, 1'b1);
      end
      finish_pkt(1'b1, 1'b0, 1'b0, "R2 single error");

      // R8 window start alone
      finish_pkt(1'b0, 1'b0, 1'b1, "R8 window start");

      // R3 double error in byte 20
      for (int k = 0; k < 13; k++)
         send(13 + k, (k == 7) ? corrupt(benc(4'(k)), 2) : benc(4'(k)), 1'b1);
      finish_pkt(1'b1, 1'b0, 1'b0, "R3 double error");

      // R9 packet end during host access, both formats
      for (int k = 0; k < 13; k++) send(13 + k, benc(4'(15 - k)), 1'b1);
      finish_pkt(1'b1, 1'b1, 1'b0, "R9 busy fmt2");
      for (int k = 0; k < 7; k++) send(15 + k, 8'(k * 37 + 1), 1'b0);
      finish_pkt(1'b0, 1'b1, 1'b0, "R9 busy fmt1");
      finish_pkt(1'b0, 1'b0, 1'b0, "R5 fmt1 commit");

      // R8 commit and window start in one cycle
      for (int k = 0; k < 13; k++) send(13 + k, benc(4'(k + 2)), 1'b1);
      finish_pkt(1'b1, 1'b0, 1'b1, "R8 commit wins");

      // R11 out-of-range bytes, one with a double error
      send(12, 8'h00 ^ 8'h03, 1'b1);
      send(26, 8'h5A, 1'b1);
      send(22, 8'hC3, 1'b0);
      send(14, 8'h77, 1'b0);
      finish_pkt(1'b0, 1'b0, 1'b0, "R11 fmt1 range");
      finish_pkt(1'b1, 1'b0, 1'b0, "R11 fmt2 range");

      // constrained random packets
      for (int p = 0; p < 60; p++) begin
         logic f2 = 1'($urandom_range(1));
         logic busy = ($urandom_range(4) == 0);
         logic fs = ($urandom_range(3) == 0);
         if (f2) begin
            for (int k = 0; k < 13; k++) begin
               int e = $urandom_range(19);
               int n = (e == 0) ? 2 : (e < 6) ? 1 : 0;
               send(13 + k, corrupt(benc(4'($urandom_range(15))), n), 1'b1);
            end
         end else begin
            for (int k = 0; k < 7; k++) send(15 + k, 8'($urandom_range(255)), 1'b0);
         end
         finish_pkt(f2, busy, fs, "random");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule